// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs local bus cycles for a processor-style master. Each cycle moves through the phases T1, T2 and T3. After T3 there may be any number of TW wait phases, and the cycle ends with T4. Four cycle kinds are supported: memory read, IO read, write and interrupt acknowledge.

When a request is accepted, the block latches three things: the cycle kind, whether the upper data byte takes part, and a status bit. From then on it drives three pins:

- **Upper-byte enable (active low).** This pin is time-shared. In T1 it acts as the byte enable. From T2 to T4 it carries the latched status bit.
- **Read strobe (active low).** For read cycles it is asserted half a clock into T2, once the bus has turned around. It stays asserted through T3 and every TW.
- **Memory/IO status bit.** It tells the addressed side whether the cycle targets memory or IO.

Each pin is presented as a value plus an output-enable. When the hold-acknowledge input is high, all enables drop, so the bus can be handed to another master. While hold is high, no new cycle starts.

A synchronized ready input sets the length of the cycle. It is looked at on the clock edge that ends T3 and on the edge that ends each TW. While it is low, wait phases are added.

Top module: `bus_cycle_seq`

## Requirements
- R1: After a synchronous reset the phase output is 0 (idle), the byte enable, read strobe and memory/IO outputs are all high, and all three output enables are 1 (hold_ack held low during reset).
- R2: From idle, a request present at a clock edge while hold_ack is low moves the phase to T1 (code 1) at that edge. T1 is always followed by T2 (code 2), and T2 by T3 (code 3).
- R3: On the edge that ends T3 or TW, ready_sync high moves the phase to T4 (code 5) and ready_sync low moves it to TW (code 4). TW repeats until ready_sync is seen high.
- R4: On the edge that ends T4, a request with hold_ack low starts a new T1 at once. Otherwise the phase returns to idle.
- R5: In T1 the byte-enable value is low when the latched upper flag is 1 or the latched kind is interrupt acknowledge (kind code 3). Otherwise it is high. Kind codes: 0 memory read, 1 IO read, 2 write, 3 interrupt acknowledge.
- R6: In T2, T3, TW and T4 the byte-enable value equals the status bit latched with the request.
- R7: For a read cycle (kind 0 or 1), the read strobe is high during the first half of T2. It is low from the falling clock edge inside T2 through T3 and every TW. It is high in idle, T1 and T4, and for all other kinds.
- R8: From T1 to T4 the memory/IO value is 1 for memory read and write, and 0 for IO read and interrupt acknowledge. In idle it is 1.
- R9: The three output enables register the inverse of hold_ack: they are 0 from the edge after hold_ack is sampled high. While hold_ack is high, no new cycle starts.
- R10: Kind, upper flag and status bit are captured on the edge that enters T1. Changes on the request inputs during a cycle have no effect on that cycle's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; phases advance on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request to start a bus cycle |
| req_kind | input | 2 | Cycle kind: 0 memory read, 1 IO read, 2 write, 3 interrupt acknowledge |
| req_upper | input | 1 | Upper data byte takes part in the cycle |
| req_status | input | 1 | Status bit shown on the byte-enable pin from T2 to T4 |
| ready_sync | input | 1 | Synchronized ready; low adds wait phases |
| hold_ack | input | 1 | Bus granted to another master; floats the outputs |
| phase_o | output | 3 | Current phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4 |
| hi_en_n_o | output | 1 | Byte-enable / status pin value |
| hi_en_oe_o | output | 1 | Output enable for hi_en_n_o |
| rd_n_o | output | 1 | Read strobe value, active low |
| rd_oe_o | output | 1 | Output enable for rd_n_o |
| mio_o | output | 1 | Memory/IO status value |
| mio_oe_o | output | 1 | Output enable for mio_o |

## Verification
The assertions assume the following about the inputs:

- ready_sync, hold_ack and the request inputs are already synchronous to clk.
- Reset is held for at least one rising and one falling edge, so the half-cycle flag clears together with the phase register.

The bench meets these conditions by changing every input just after the falling edge, well clear of both clock edges. It samples the strobe once after each edge so that both halves of T2 are observed.

Random stimulus mixes requests, ready and hold freely, including hold in the middle of a cycle. On top of that, directed windows cover long wait runs, hold held across a pending request, and request fields that change on every clock during a cycle.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int PHASE_W = 3;
  localparam int KIND_W  = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  typedef enum logic [KIND_W-1:0] {
    CYC_MEMRD = 2'd0,
    CYC_IORD  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_INTA  = 2'd3
  } cyc_e;

  typedef struct packed {
    cyc_e kind;
    logic upper;
    logic stat;
  } cyc_req_t;

  function automatic logic is_read(input cyc_e k);
    return (k == CYC_MEMRD) || (k == CYC_IORD);
  endfunction

  function automatic logic in_strobe_window(input phase_e p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_TW);
  endfunction
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req_valid,
  input  cyc_req_t req_in,
  input  logic     ready_sync,
  input  logic     hold_ack,
  output phase_e   phase_q,
  output phase_e   phase_d,
  output cyc_req_t cur_d
);
  cyc_req_t cur_q;
  logic     start_ok;

  assign start_ok = req_valid && !hold_ack;

  always_comb begin
    phase_d = phase_q;
    cur_d   = cur_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_ok) begin
          phase_d = PH_T1;
          cur_d   = req_in;
        end
      end
      PH_T1: phase_d = PH_T2;
      PH_T2: phase_d = PH_T3;
      PH_T3, PH_TW: phase_d = ready_sync ? PH_T4 : PH_TW;
      PH_T4: begin
        if (start_ok) begin
          phase_d = PH_T1;
          cur_d   = req_in;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cur_q   <= '{kind: CYC_MEMRD, upper: 1'b0, stat: 1'b1};
    end else begin
      phase_q <= phase_d;
      cur_q   <= cur_d;
    end
  end
endmodule

// File: rtl/bus_seq_outgen.sv
module bus_seq_outgen
  import bus_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  phase_e   phase_d,
  input  cyc_req_t cur_d,
  input  logic     hold_ack,
  output logic     hi_en_n_q,
  output logic     mio_q,
  output logic     oe_q,
  output logic     rd_win_q
);
  logic hi_en_n_nx;
  logic mio_nx;
  logic rd_win_nx;

  always_comb begin
    unique case (phase_d)
      PH_IDLE: hi_en_n_nx = 1'b1;
      PH_T1:   hi_en_n_nx = !(cur_d.upper || (cur_d.kind == CYC_INTA));
      default: hi_en_n_nx = cur_d.stat;
    endcase
    if (phase_d == PH_IDLE) mio_nx = 1'b1;
    else mio_nx = (cur_d.kind == CYC_MEMRD) || (cur_d.kind == CYC_WRITE);
    rd_win_nx = in_strobe_window(phase_d) && is_read(cur_d.kind);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_en_n_q <= 1'b1;
      mio_q     <= 1'b1;
      oe_q      <= 1'b1;
      rd_win_q  <= 1'b0;
    end else begin
      hi_en_n_q <= hi_en_n_nx;
      mio_q     <= mio_nx;
      oe_q      <= !hold_ack;
      rd_win_q  <= rd_win_nx;
    end
  end
endmodule

// File: rtl/bus_seq_turnaround.sv
module bus_seq_turnaround (
  input  logic clk,
  input  logic rst,
  input  logic rd_win,
  output logic rd_active
);
  logic half_q;

  always_ff @(negedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= rd_win;
  end

  assign rd_active = rd_win && half_q;
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int KIND_BITS  = KIND_W,
  parameter int PHASE_BITS = PHASE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [KIND_BITS-1:0]  req_kind,
  input  logic                  req_upper,
  input  logic                  req_status,
  input  logic                  ready_sync,
  input  logic                  hold_ack,
  output logic [PHASE_BITS-1:0] phase_o,
  output logic                  hi_en_n_o,
  output logic                  hi_en_oe_o,
  output logic                  rd_n_o,
  output logic                  rd_oe_o,
  output logic                  mio_o,
  output logic                  mio_oe_o
);
  cyc_req_t req_in;
  phase_e   phase_q;
  phase_e   phase_d;
  cyc_req_t cur_d;
  logic     hi_en_n_q;
  logic     mio_q;
  logic     oe_q;
  logic     rd_win_q;
  logic     rd_active;

  assign req_in = '{kind: cyc_e'(req_kind), upper: req_upper, stat: req_status};

  bus_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_in     (req_in),
    .ready_sync (ready_sync),
    .hold_ack   (hold_ack),
    .phase_q    (phase_q),
    .phase_d    (phase_d),
    .cur_d      (cur_d)
  );

  bus_seq_outgen u_out (
    .clk       (clk),
    .rst       (rst),
    .phase_d   (phase_d),
    .cur_d     (cur_d),
    .hold_ack  (hold_ack),
    .hi_en_n_q (hi_en_n_q),
    .mio_q     (mio_q),
    .oe_q      (oe_q),
    .rd_win_q  (rd_win_q)
  );

  bus_seq_turnaround u_turn (
    .clk       (clk),
    .rst       (rst),
    .rd_win    (rd_win_q),
    .rd_active (rd_active)
  );

  assign phase_o    = PHASE_BITS'(phase_q);
  assign hi_en_n_o  = hi_en_n_q;
  assign hi_en_oe_o = oe_q;
  assign rd_n_o     = !rd_active;
  assign rd_oe_o    = oe_q;
  assign mio_o      = mio_q;
  assign mio_oe_o   = oe_q;
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       ready_sync,
  input logic       hold_ack,
  input logic [2:0] phase_o,
  input logic       hi_en_n_o,
  input logic       hi_en_oe_o,
  input logic       rd_n_o,
  input logic       rd_oe_o,
  input logic       mio_o,
  input logic       mio_oe_o
);
  assert_t1_then_t2_R2: assert property (@(posedge clk) disable iff (rst)
    phase_o == 3'd1 |=> phase_o == 3'd2);

  assert_ready_ends_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd3 || phase_o == 3'd4) && ready_sync |=> phase_o == 3'd5);

  assert_no_ready_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd3 || phase_o == 3'd4) && !ready_sync |=> phase_o == 3'd4);

  assert_t4_to_idle_R4: assert property (@(posedge clk) disable iff (rst)
    phase_o == 3'd5 && !req_valid |=> phase_o == 3'd0);

  assert_status_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd3 || phase_o == 3'd4 || phase_o == 3'd5) |-> $stable(hi_en_n_o));

  assert_strobe_off_R7: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd0 || phase_o == 3'd1 || phase_o == 3'd5) |-> rd_n_o);

  assert_idle_pins_R8: assert property (@(posedge clk) disable iff (rst)
    phase_o == 3'd0 |-> mio_o && hi_en_n_o);

  assert_float_R9: assert property (@(posedge clk) disable iff (rst)
    hold_ack |=> !hi_en_oe_o && !rd_oe_o && !mio_oe_o);

  assert_hold_blocks_start_R9: assert property (@(posedge clk) disable iff (rst)
    phase_o == 3'd0 && hold_ack |=> phase_o == 3'd0);
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .ready_sync (ready_sync),
  .hold_ack   (hold_ack),
  .phase_o    (phase_o),
  .hi_en_n_o  (hi_en_n_o),
  .hi_en_oe_o (hi_en_oe_o),
  .rd_n_o     (rd_n_o),
  .rd_oe_o    (rd_oe_o),
  .mio_o      (mio_o),
  .mio_oe_o   (mio_oe_o)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic       req_upper = 1'b0;
  logic       req_status = 1'b0;
  logic       ready_sync = 1'b1;
  logic       hold_ack = 1'b0;
  logic [2:0] phase_o;
  logic       hi_en_n_o, hi_en_oe_o, rd_n_o, rd_oe_o, mio_o, mio_oe_o;

  int checks = 0;
  int errors = 0;

  localparam int NCYC = 3000;

  always #5 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_upper(req_upper), .req_status(req_status), .ready_sync(ready_sync),
    .hold_ack(hold_ack), .phase_o(phase_o), .hi_en_n_o(hi_en_n_o),
    .hi_en_oe_o(hi_en_oe_o), .rd_n_o(rd_n_o), .rd_oe_o(rd_oe_o),
    .mio_o(mio_o), .mio_oe_o(mio_oe_o)
  );

  // bench model state
  logic [2:0] ms = 3'd0;
  logic [1:0] mk = 2'd0;
  logic       mu = 1'b0;
  logic       mst = 1'b1;
  logic       moe = 1'b1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d phase=%0d t=%0t", tag, act, exp, ms, $time);
    end
  endtask

  function automatic logic exp_hi(input logic [2:0] s, input logic [1:0] k,
                                  input logic u, input logic st);
    if (s == 3'd0) return 1'b1;
    if (s == 3'd1) return !(u || k == 2'd3);
    return st;
  endfunction

  function automatic logic exp_mio(input logic [2:0] s, input logic [1:0] k);
    if (s == 3'd0) return 1'b1;
    return (k == 2'd0) || (k == 2'd2);
  endfunction

  task automatic model_step();
    logic go;
    go = req_valid && !hold_ack;
    moe = rst ? 1'b1 : !hold_ack;
    if (rst) ms = 3'd0;
    else begin
      case (ms)
        3'd0: if (go) begin ms = 3'd1; mk = req_kind; mu = req_upper; mst = req_status; end
        3'd1: ms = 3'd2;
        3'd2: ms = 3'd3;
        3'd3, 3'd4: ms = ready_sync ? 3'd5 : 3'd4;
        3'd5: if (go) begin ms = 3'd1; mk = req_kind; mu = req_upper; mst = req_status; end
              else ms = 3'd0;
        default: ms = 3'd0;
      endcase
    end
  endtask

  task automatic drive(input int n);
    rst = (n < 4);
    if (n >= 10 && n < 30) begin
      // R3: long run of wait phases on a memory read
      req_valid = 1'b1; req_kind = 2'd0; req_upper = 1'b1; req_status = 1'b0;
      hold_ack = 1'b0; ready_sync = (n == 25);
    end else if (n >= 40 && n < 52) begin
      // R9: hold across a pending request keeps idle
      req_valid = 1'b1; req_kind = 2'd1; hold_ack = (n < 50); ready_sync = 1'b1;
    end else if (n >= 60 && n < 80) begin
      // R10: request fields change every clock during a cycle
      req_valid = 1'b1; req_kind = 2'($urandom); req_upper = 1'($urandom);
      req_status = 1'($urandom); hold_ack = 1'b0; ready_sync = ($urandom % 3) != 0;
    end else begin
      req_valid  = ($urandom % 4) != 0;
      req_kind   = 2'($urandom);
      req_upper  = 1'($urandom);
      req_status = 1'($urandom);
      ready_sync = ($urandom % 5) > 1;
      hold_ack   = ($urandom % 10) == 0;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < NCYC; n++) begin
      @(posedge clk);
      model_step();
      #2;
      if (!rst) begin
        chk(ms == 3'd0 ? "R1/R4 phase" : (ms >= 3'd3 ? "R3 phase" : "R2 phase"),
            phase_o, ms);
        chk(ms == 3'd1 ? "R5 hi_en" : (ms == 3'd0 ? "R1 hi_en" : "R6 hi_en"),
            hi_en_n_o, exp_hi(ms, mk, mu, mst));
        chk("R8 mio", mio_o, exp_mio(ms, mk));
        chk("R9 oe", {hi_en_oe_o, rd_oe_o, mio_oe_o}, {3{moe}});
        // R7: first half of T2 stays high; T3/TW low for reads
        chk("R7 rd first half", rd_n_o,
            !((mk < 2'd2) && (ms == 3'd3 || ms == 3'd4)));
      end else if (n == 3) begin
        chk("R1 reset phase", phase_o, 0);
        chk("R1 reset pins", {hi_en_n_o, rd_n_o, mio_o, hi_en_oe_o, rd_oe_o, mio_oe_o}, 6'b111111);
      end
      @(negedge clk);
      #1;
      if (!rst)
        chk("R7 rd second half", rd_n_o,
            !((mk < 2'd2) && (ms == 3'd2 || ms == 3'd3 || ms == 3'd4)));
      #1;
      drive(n + 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(NCYC * 10 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule